// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block paces a small 8-bit controller core from its oscillator clock. A configuration input, captured while reset is held, chooses whether one instruction cycle spans two or four oscillator clocks. Inside each cycle the block drives a one-hot phase strobe. On the final phase it raises a cycle enable, a timer clock enable, a fetch enable and, unless the cycle is a discarded one, an execute enable.

The core's decoder supplies a small class code for the instruction being completed, together with the outcome of any skip test. Control transfers, writes to the program counter and skips whose test comes out true all cost two cycles. The second of those cycles is a bubble: the prefetched word is thrown away, execute stays low and fetch continues from the new program counter. A sleep request taken at a cycle boundary freezes the sequencer until a wake input arrives.

Top module: `ics_top`

## Requirements
- R1: With `mode_i` low during reset, `cycle_en_o` pulses once every 2 oscillator clocks. With it high, the pulse comes once every 4 clocks.
- R2: `phase_stb_o` is one-hot while awake. Bit k is high during phase k. Phase 0 is the first phase after reset, and `cycle_en_o` is high only on the last phase (1 in two-clock mode, 3 in four-clock mode).
- R3: `timer_en_o` pulses at the oscillator rate divided by the selected ratio, and it coincides with `cycle_en_o`.
- R4: `fetch_en_o` pulses on every cycle end, and that includes bubble cycles.
- R5: Class code 1 (jump, call or any return form) at a cycle end makes the following instruction cycle a bubble.
- R6: Class code 2 (conditional skip) makes the following cycle a bubble only if `cond_i` is high at that cycle end. Otherwise the next cycle is normal.
- R7: Class code 3 (instruction that writes the program counter) makes the following cycle a bubble.
- R8: Class code 0 and codes 4 to 7 complete in one cycle, and `exec_en_o` pulses at every cycle end outside a bubble.
- R9: During a bubble, `bubble_o` is high for the whole cycle and `exec_en_o` stays low. The class and condition inputs are ignored, and the cycle after it is normal.
- R10: Changes of `mode_i` after reset has been released do not change the cycle length until the next reset.
- R11: `sleep_req_i` sampled high at a cycle end stops the phase counter. From the next clock, all strobes and enables and `bubble_o` are low. A high `wake_i` resumes counting at phase 0 from the clock after it. Outside sleep, `wake_i` has no effect, and `sleep_req_i` is ignored away from cycle ends.
- R12: After reset the block is awake, in phase 0, and not in a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low; also captures `mode_i` |
| mode_i | input | 1 | Ratio select: 0 = two clocks per cycle, 1 = four |
| insn_class_i | input | 3 | Class code of the instruction ending this cycle |
| cond_i | input | 1 | Skip test outcome for class 2 |
| sleep_req_i | input | 1 | Enter sleep at the current cycle end |
| wake_i | input | 1 | Leave sleep |
| phase_stb_o | output | 4 | One-hot phase strobes |
| cycle_en_o | output | 1 | Once-per-instruction-cycle enable |
| timer_en_o | output | 1 | Timer clock enable |
| fetch_en_o | output | 1 | Fetch the next program word |
| exec_en_o | output | 1 | Commit the current instruction |
| bubble_o | output | 1 | Current cycle is a discarded flush cycle |

## Verification
The assertions assume that reset is held low for at least one clock edge before any property is checked. They also assume that `insn_class_i` and `cond_i` are stable and meaningful at the clock edge where `cycle_en_o` is high. The bench drives every input only at falling edges, so each value is settled well before the rising edge that samples it. It walks every class code with both condition values through both ratio settings. It also toggles `mode_i` after reset and pulses the sleep and wake inputs at times that fall both on and off cycle ends.

// File: rtl/ics_pkg.sv
package ics_pkg;

   localparam int CLS_W = 3;

   typedef enum logic [CLS_W-1:0] {
      CLS_PLAIN = 3'd0,
      CLS_XFER  = 3'd1,
      CLS_SKIP  = 3'd2,
      CLS_PCWR  = 3'd3
   } insn_cls_e;

   // True when the instruction ending now costs a second (flush) cycle.
   function automatic logic needs_flush(input logic [CLS_W-1:0] cls, input logic cond);
      case (cls)
         CLS_XFER: needs_flush = 1'b1;
         CLS_PCWR: needs_flush = 1'b1;
         CLS_SKIP: needs_flush = cond;
         default:  needs_flush = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/ics_phase_gen.sv
module ics_phase_gen #(
   parameter int FAST_RATIO = 2,
   parameter int SLOW_RATIO = 4,
   localparam int PH_W = $clog2(SLOW_RATIO)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode_i,
   input  logic            sleep_req_i,
   input  logic            wake_i,
   output logic [PH_W-1:0] ph_o,
   output logic            cyc_end_o,
   output logic            asleep_o
);

   localparam logic [PH_W-1:0] LAST_FAST = PH_W'(FAST_RATIO - 1);
   localparam logic [PH_W-1:0] LAST_SLOW = PH_W'(SLOW_RATIO - 1);

   initial begin
      assert (FAST_RATIO >= 2 && SLOW_RATIO > FAST_RATIO)
         else $error("ics_phase_gen: need 2 <= FAST_RATIO < SLOW_RATIO");
   end

   logic            mode_q;
   logic [PH_W-1:0] ph_q;
   logic            asleep_q;
   logic [PH_W-1:0] last_ph;

   assign last_ph   = mode_q ? LAST_SLOW : LAST_FAST;
   assign cyc_end_o = !asleep_q && (ph_q == last_ph);
   assign ph_o      = ph_q;
   assign asleep_o  = asleep_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= mode_i;
         ph_q     <= '0;
         asleep_q <= 1'b0;
      end else if (asleep_q) begin
         if (wake_i) asleep_q <= 1'b0;
      end else begin
         ph_q <= cyc_end_o ? '0 : ph_q + PH_W'(1);
         if (cyc_end_o && sleep_req_i) asleep_q <= 1'b1;
      end
   end

   // R1: a cycle end is never followed directly by another one
   a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_end_o |=> !cyc_end_o);

   // R10: the captured ratio holds once reset is released
   a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(mode_q));

   // R11: the phase counter stays still while asleep
   a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      asleep_q && $past(asleep_q) |-> $stable(ph_q));

endmodule

// File: rtl/ics_strobes.sv
module ics_strobes #(
   parameter int SLOW_RATIO = 4,
   localparam int PH_W = $clog2(SLOW_RATIO)
) (
   input  logic [PH_W-1:0]       ph_i,
   input  logic                  active_i,
   output logic [SLOW_RATIO-1:0] stb_o
);

   for (genvar i = 0; i < SLOW_RATIO; i++) begin : g_stb
      assign stb_o[i] = active_i && (ph_i == PH_W'(i));
   end

endmodule

// File: rtl/ics_flow.sv
module ics_flow
   import ics_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_end_i,
   input  logic [CLS_W-1:0] cls_i,
   input  logic             cond_i,
   output logic             bubble_q_o
);

   logic bub_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         bub_q <= 1'b0;
      else if (cyc_end_i) bub_q <= bub_q ? 1'b0 : needs_flush(cls_i, cond_i);
   end

   assign bubble_q_o = bub_q;

   // R9: a bubble never lasts past its own cycle end
   a_r9_single_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      bub_q && cyc_end_i |=> !bub_q);

   // R5: a control transfer retiring normally is followed by a bubble
   a_r5_xfer_flush: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_end_i && !bub_q && cls_i == CLS_XFER |=> bub_q);

   // R7: a program counter write retiring normally is followed by a bubble
   a_r7_pcwr_flush: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_end_i && !bub_q && cls_i == CLS_PCWR |=> bub_q);

   // R6: a skip whose test is false does not flush
   a_r6_skip_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_end_i && !bub_q && cls_i == CLS_SKIP && !cond_i |=> !bub_q);

endmodule

// File: rtl/ics_top.sv
module ics_top
   import ics_pkg::*;
#(
   parameter int FAST_RATIO = 2,
   parameter int SLOW_RATIO = 4,
   localparam int PH_W = $clog2(SLOW_RATIO)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mode_i,
   input  logic [CLS_W-1:0]      insn_class_i,
   input  logic                  cond_i,
   input  logic                  sleep_req_i,
   input  logic                  wake_i,
   output logic [SLOW_RATIO-1:0] phase_stb_o,
   output logic                  cycle_en_o,
   output logic                  timer_en_o,
   output logic                  fetch_en_o,
   output logic                  exec_en_o,
   output logic                  bubble_o
);

   logic [PH_W-1:0] ph;
   logic            cyc_end;
   logic            asleep;
   logic            bub_q;

   ics_phase_gen #(
      .FAST_RATIO (FAST_RATIO),
      .SLOW_RATIO (SLOW_RATIO)
   ) u_phase (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode_i),
      .sleep_req_i (sleep_req_i),
      .wake_i      (wake_i),
      .ph_o        (ph),
      .cyc_end_o   (cyc_end),
      .asleep_o    (asleep)
   );

   ics_strobes #(
      .SLOW_RATIO (SLOW_RATIO)
   ) u_stb (
      .ph_i     (ph),
      .active_i (!asleep),
      .stb_o    (phase_stb_o)
   );

   ics_flow u_flow (
      .clk        (clk),
      .rst_n      (rst_n),
      .cyc_end_i  (cyc_end),
      .cls_i      (insn_class_i),
      .cond_i     (cond_i),
      .bubble_q_o (bub_q)
   );

   assign cycle_en_o = cyc_end;
   assign timer_en_o = cyc_end;
   assign fetch_en_o = cyc_end;
   assign exec_en_o  = cyc_end && !bub_q;
   assign bubble_o   = bub_q && !asleep;

   // R2: at most one phase strobe at a time
   a_r2_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(phase_stb_o));

   // R2: the cycle enable only rises alongside a phase strobe
   a_r2_end_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_en_o |-> $countones(phase_stb_o) == 1);

   // R9: nothing is committed in a flush cycle
   a_r9_no_exec_in_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_o |-> !exec_en_o);

   // R11: everything is quiet while asleep
   a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> (phase_stb_o == '0) && !fetch_en_o && !exec_en_o && !bubble_o);

endmodule

// File: tb/sim_ics_top.sv
module sim_ics_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_i = 1'b0;
   logic [2:0] insn_class_i = '0;
   logic       cond_i = 1'b0;
   logic       sleep_req_i = 1'b0;
   logic       wake_i = 1'b0;
   logic [3:0] phase_stb_o;
   logic       cycle_en_o, timer_en_o, fetch_en_o, exec_en_o, bubble_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   // bench reference state
   int    m_ph;
   bit    m_bub, m_sl, m_mode;
   string m_why;
   logic [15:0] lfsr = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   ics_top u0 (
      .clk, .rst_n, .mode_i, .insn_class_i, .cond_i, .sleep_req_i, .wake_i,
      .phase_stb_o, .cycle_en_o, .timer_en_o, .fetch_en_o, .exec_en_o, .bubble_o
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int n   = m_mode ? 4 : 2;
      bit ce  = !m_sl && (m_ph == n - 1);
      string rt = m_sl ? "R11" : (m_mode ? "R1_slow/R10" : "R1_fast/R10");
      chk(m_sl ? "R11" : "R2", "phase_stb", int'(phase_stb_o), m_sl ? 0 : (1 << m_ph));
      chk(rt, "cycle_en", int'(cycle_en_o), int'(ce));
      chk(m_sl ? "R11" : "R3", "timer_en", int'(timer_en_o), int'(ce));
      chk(m_sl ? "R11" : "R4", "fetch_en", int'(fetch_en_o), int'(ce));
      chk(m_sl ? "R11" : (m_bub ? "R9" : "R8"), "exec_en", int'(exec_en_o), int'(ce && !m_bub));
      chk(m_sl ? "R11" : m_why, "bubble", int'(bubble_o), int'(m_bub && !m_sl));
   endtask

   task automatic run_mode(input bit md, input int steps);
      rst_n  = 1'b0;
      mode_i = md;
      sleep_req_i = 1'b0;
      wake_i = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_ph = 0; m_bub = 0; m_sl = 0; m_mode = md; m_why = "R12";
      // R12: reset state
      chk("R12", "phase_stb", int'(phase_stb_o), 1);
      chk("R12", "bubble", int'(bubble_o), 0);
      chk("R12", "cycle_en", int'(cycle_en_o), 0);
      mode_i = !md;   // R10: later changes must be ignored
      for (int t = 0; t < steps; t++) begin
         int  n;
         bit  ce, nb, ns;
         int  np;
         string nw;
         compare_all();
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         insn_class_i = 3'(t % 8);
         cond_i       = lfsr[0];
         sleep_req_i  = ((t % 23) == 5) || ((t % 23) == 6);
         wake_i       = (t % 9) == 0;
         n  = m_mode ? 4 : 2;
         ce = !m_sl && (m_ph == n - 1);
         np = m_ph; nb = m_bub; ns = m_sl; nw = m_why;
         if (m_sl) begin
            if (wake_i) ns = 0;
         end else begin
            np = ce ? 0 : m_ph + 1;
            if (ce) begin
               if (m_bub) begin
                  nb = 0; nw = "R9";
               end else begin
                  case (insn_class_i)
                     3'd1: begin nb = 1; nw = "R5"; end
                     3'd2: begin nb = cond_i; nw = "R6"; end
                     3'd3: begin nb = 1; nw = "R7"; end
                     default: begin nb = 0; nw = "R8"; end
                  endcase
               end
               if (sleep_req_i) ns = 1;
            end
         end
         @(posedge clk);
         m_ph = np; m_bub = nb; m_sl = ns; m_why = nw;
         @(negedge clk);
      end
   endtask

   initial begin
      run_mode(1'b0, 600);
      run_mode(1'b1, 900);
      run_mode(1'b0, 300);
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule